// File: doc/BRIEF.md
# Refresh and Start-Up Scheduler for an EDO DRAM

This block keeps an asynchronous-page DRAM alive. After reset it holds the memory idle through a long power-up pause. It then runs a short burst of warm-up refresh cycles, and after that it issues one refresh cycle for each elapsed interval. Every refresh uses the CAS-before-RAS form: the device's internal row counter picks the row, so the scheduler never drives an address.

The scheduler shares the memory pins with the access sequencer. It asks for the bus with a request line and waits for a grant. It then plays out one refresh cycle on RAS, CAS and WE, and gives the bus back when the cycle is over.

While it waits for a grant, the interval timer keeps running. Each missed interval is held in a small counter of refreshes owed. When the grant returns, the owed refreshes run back to back. If the counter is already full and another interval expires, the extra refresh is dropped and a sticky error is raised.

A ready output tells the rest of the controller when the memory may be used. Host access grants are held off until ready is high. Every duration is a parameter counted in clock cycles.

Top module: `cbr_refresh_sched`

## Requirements
- R1: After reset is released, no refresh is requested for PAUSE_CYC cycles. Then, with the grant held high, exactly WARMUP_CNT refresh cycles run back to back before ready rises.
- R2: ready is 0 from reset until the precharge of the last warm-up cycle has finished. Once high, it stays high until the next reset.
- R3: host_gnt equals host_req while ready is 1, and is 0 while ready is 0.
- R4: Each refresh cycle has three phases. First cas_n is low for LEAD_CYC cycles while ras_n is high. Then both are low for RASLO_CYC cycles. Then both are high for at least PRE_CYC cycles before cas_n may fall again. ras_n is never low while cas_n is high.
- R5: ref_req is 1 whenever a refresh is owed or a refresh cycle is in progress. A cycle starts (cas_n falls) only on the clock after ref_gnt was sampled as 1 with a refresh owed. While ref_gnt is 0 and no cycle is running, cas_n does not fall.
- R6: we_n is 1 at all times, which satisfies the write-enable-high setup and hold around the RAS fall.
- R7: Once ready is 1, one refresh becomes owed every INTERVAL_CYC cycles, whether or not the grant is present. Up to PEND_MAX owed refreshes are kept, and they run back to back while the grant is present.
- R8: If an interval expires while PEND_MAX refreshes are already owed and none finishes in that cycle, ovf_err becomes 1 and stays 1 until reset, and the count of owed refreshes stays at PEND_MAX.
- R9: With the grant held high, any ROWS consecutive refresh cycles after ready start within ROWS*INTERVAL_CYC cycles of each other, which keeps every row inside the refresh period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Bus grant from the access sequencer |
| host_req | input | 1 | Host access request |
| ref_req | output | 1 | Bus request for refresh |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low, held high |
| ready | output | 1 | Initialization complete |
| host_gnt | output | 1 | Host access grant, gated by ready |
| ovf_err | output | 1 | Sticky overflow of owed refreshes |

## Verification
The bench runs the design next to a behavioural model under four grant patterns, each of which brings out a different part of the design:
- A grant held permanently high exposes the pause length, the size of the warm-up burst and the interval spacing.
- A grant withheld for a few intervals shows that the timer keeps running and that the owed refreshes then drain back to back.
- A grant withheld for longer than the counter can cover separates a saturating counter with a sticky error from one that wraps or drops the error.
- A reset applied in mid-run shows that ready and the error flag both return to 0.

// File: rtl/crs_pkg.sv
package crs_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_LEAD  = 2'd1,
      SQ_RASLO = 2'd2,
      SQ_PRE   = 2'd3
   } seq_e;

   typedef enum logic [1:0] {
      PH_PAUSE = 2'd0,
      PH_WARM  = 2'd1,
      PH_RUN   = 2'd2
   } phase_e;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/crs_interval_timer.sv
module crs_interval_timer #(
   parameter int unsigned INTERVAL_CYC = 1560
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int unsigned TW = $clog2(INTERVAL_CYC);
   localparam logic [TW-1:0] LAST = TW'(INTERVAL_CYC - 1);

   logic [TW-1:0] tcnt;

   generate
      if ((INTERVAL_CYC & (INTERVAL_CYC - 1)) == 0) begin : g_wrap
         // power of two: natural wrap of the counter
         always_ff @(posedge clk) begin
            if (!rst_n || !run) tcnt <= '0;
            else                tcnt <= tcnt + 1'b1;
         end
      end else begin : g_cmp
         always_ff @(posedge clk) begin
            if (!rst_n || !run)   tcnt <= '0;
            else if (tcnt == LAST) tcnt <= '0;
            else                   tcnt <= tcnt + 1'b1;
         end
      end
   endgenerate

   assign tick = run && (tcnt == LAST);

   p_tick_needs_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> $past(run));
endmodule

// File: rtl/crs_pend_ctr.sv
module crs_pend_ctr #(
   parameter int unsigned PEND_MAX   = 8,
   parameter int unsigned WARMUP_CNT = 8,
   localparam int unsigned PW        = $clog2(PEND_MAX + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          tick,
   input  logic          done,
   output logic [PW-1:0] pend,
   output logic          ovf
);
   localparam logic [PW-1:0] MAXV  = PW'(PEND_MAX);
   localparam logic [PW-1:0] WARMV = PW'(WARMUP_CNT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= '0;
         ovf  <= 1'b0;
      end else if (load) begin
         pend <= WARMV;
      end else begin
         unique case ({tick, done})
            2'b10: if (pend == MAXV) ovf <= 1'b1;
                   else              pend <= pend + 1'b1;
            2'b01: pend <= pend - 1'b1;
            default: ;
         endcase
      end
   end

   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pend <= MAXV);
   p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);
   p_ovf_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf) |-> $past(pend) == MAXV);
   p_done_owed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> pend != '0);
endmodule

// File: rtl/crs_init_ctl.sv
module crs_init_ctl
   import crs_pkg::*;
#(
   parameter int unsigned PAUSE_CYC = 20000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pend_zero,
   input  logic seq_busy,
   output logic load_warm,
   output logic ready
);
   localparam int unsigned PCW = $clog2(PAUSE_CYC);
   localparam logic [PCW-1:0] LASTP = PCW'(PAUSE_CYC - 1);

   phase_e         phase;
   logic [PCW-1:0] pcnt;

   assign load_warm = (phase == PH_PAUSE) && (pcnt == LASTP);
   assign ready     = (phase == PH_RUN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_PAUSE;
         pcnt  <= '0;
      end else begin
         unique case (phase)
            PH_PAUSE: if (load_warm) phase <= PH_WARM;
                      else           pcnt  <= pcnt + 1'b1;
            PH_WARM:  if (pend_zero) phase <= PH_RUN;
            default:  ;
         endcase
      end
   end

   p_quiet_pause_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_PAUSE) |-> (pend_zero && !seq_busy));
   p_ready_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready);
endmodule

// File: rtl/crs_cbr_seq.sv
module crs_cbr_seq
   import crs_pkg::*;
#(
   parameter int unsigned LEAD_CYC  = 1,
   parameter int unsigned RASLO_CYC = 6,
   parameter int unsigned PRE_CYC   = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic owed,
   input  logic ref_gnt,
   output logic ras_n,
   output logic cas_n,
   output logic we_n,
   output logic busy,
   output logic done
);
   localparam int unsigned MAXC = max3(LEAD_CYC, RASLO_CYC, PRE_CYC);
   localparam int unsigned SW   = (MAXC > 1) ? $clog2(MAXC) : 1;
   localparam logic [SW-1:0] LEAD_LD = SW'(LEAD_CYC - 1);
   localparam logic [SW-1:0] RAS_LD  = SW'(RASLO_CYC - 1);
   localparam logic [SW-1:0] PRE_LD  = SW'(PRE_CYC - 1);

   seq_e          state;
   logic [SW-1:0] scnt;
   logic          last;

   assign last  = (scnt == '0);
   assign busy  = (state != SQ_IDLE);
   assign done  = (state == SQ_PRE) && last;
   assign ras_n = (state != SQ_RASLO);
   assign cas_n = !((state == SQ_LEAD) || (state == SQ_RASLO));
   assign we_n  = 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SQ_IDLE;
         scnt  <= '0;
      end else begin
         unique case (state)
            SQ_IDLE:  if (owed && ref_gnt) begin
                         state <= SQ_LEAD;
                         scnt  <= LEAD_LD;
                      end
            SQ_LEAD:  if (last) begin
                         state <= SQ_RASLO;
                         scnt  <= RAS_LD;
                      end else scnt <= scnt - 1'b1;
            SQ_RASLO: if (last) begin
                         state <= SQ_PRE;
                         scnt  <= PRE_LD;
                      end else scnt <= scnt - 1'b1;
            SQ_PRE:   if (last) state <= SQ_IDLE;
                      else      scnt  <= scnt - 1'b1;
            default:  state <= SQ_IDLE;
         endcase
      end
   end

   p_ras_under_cas_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ras_n |-> !cas_n);
   p_precharge_cas_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n) |=> cas_n);
   p_start_on_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_n) |-> $past(ref_gnt && owed));
endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched
   import crs_pkg::*;
#(
   parameter int unsigned PAUSE_CYC    = 20000,
   parameter int unsigned WARMUP_CNT   = 8,
   parameter int unsigned INTERVAL_CYC = 1560,
   parameter int unsigned LEAD_CYC     = 1,
   parameter int unsigned RASLO_CYC    = 6,
   parameter int unsigned PRE_CYC      = 4,
   parameter int unsigned PEND_MAX     = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_gnt,
   input  logic host_req,
   output logic ref_req,
   output logic ras_n,
   output logic cas_n,
   output logic we_n,
   output logic ready,
   output logic host_gnt,
   output logic ovf_err
);
   localparam int unsigned PW = $clog2(PEND_MAX + 1);

   initial begin
      assert (PAUSE_CYC >= 2) else $error("PAUSE_CYC must be at least 2");
      assert (INTERVAL_CYC >= 2) else $error("INTERVAL_CYC must be at least 2");
      assert (LEAD_CYC >= 1 && RASLO_CYC >= 1 && PRE_CYC >= 1)
         else $error("refresh phase lengths must be at least 1");
      assert (LEAD_CYC + RASLO_CYC + PRE_CYC < INTERVAL_CYC)
         else $error("one refresh cycle must fit inside an interval");
      assert (WARMUP_CNT >= 1 && WARMUP_CNT <= PEND_MAX)
         else $error("WARMUP_CNT must lie in 1..PEND_MAX");
   end

   logic          tick, done, busy, load_warm;
   logic [PW-1:0] pend;
   logic          owed;

   assign owed     = (pend != '0);
   assign ref_req  = busy || owed;
   assign host_gnt = host_req && ready;

   crs_init_ctl #(.PAUSE_CYC(PAUSE_CYC)) u_init (
      .clk(clk), .rst_n(rst_n), .pend_zero(!owed), .seq_busy(busy),
      .load_warm(load_warm), .ready(ready)
   );

   crs_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(ready), .tick(tick)
   );

   crs_pend_ctr #(.PEND_MAX(PEND_MAX), .WARMUP_CNT(WARMUP_CNT)) u_pend (
      .clk(clk), .rst_n(rst_n), .load(load_warm), .tick(tick), .done(done),
      .pend(pend), .ovf(ovf_err)
   );

   crs_cbr_seq #(.LEAD_CYC(LEAD_CYC), .RASLO_CYC(RASLO_CYC), .PRE_CYC(PRE_CYC)) u_seq (
      .clk(clk), .rst_n(rst_n), .owed(owed), .ref_gnt(ref_gnt),
      .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .busy(busy), .done(done)
   );

   p_req_covers_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n |-> ref_req);
endmodule

// File: tb/test_cbr_refresh_sched.sv
module test_cbr_refresh_sched;
   localparam int CLK_PERIOD = 10;
   localparam int PAUSE    = 50;
   localparam int WARMUP   = 8;
   localparam int INTERVAL = 40;
   localparam int LEAD     = 1;
   localparam int RASLO    = 6;
   localparam int PRE      = 4;
   localparam int PMAX     = 8;
   localparam int ROWS     = 16;
   localparam int CYC_LEN  = LEAD + RASLO + PRE;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_gnt = 1'b0;
   logic host_req = 1'b0;
   logic ref_req, ras_n, cas_n, we_n, ready, host_gnt, ovf_err;

   always #(CLK_PERIOD / 2) clk = ~clk;

   cbr_refresh_sched #(
      .PAUSE_CYC(PAUSE), .WARMUP_CNT(WARMUP), .INTERVAL_CYC(INTERVAL),
      .LEAD_CYC(LEAD), .RASLO_CYC(RASLO), .PRE_CYC(PRE), .PEND_MAX(PMAX)
   ) i_cbr_refresh_sched (
      .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .host_req(host_req),
      .ref_req(ref_req), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .ready(ready), .host_gnt(host_gnt), .ovf_err(ovf_err)
   );

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;
   bit cmp_en   = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   // behavioural reference model
   int m_phase, m_pcnt, m_pend, m_tcnt, m_seq, m_scnt;
   bit m_ovf;
   int n_phase, n_pend, n_tcnt, n_seq, n_scnt, n_pcnt;
   bit b_done, b_tick, b_load;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         m_phase = 0; m_pcnt = 0; m_pend = 0; m_tcnt = 0;
         m_seq = 0; m_scnt = 0; m_ovf = 1'b0;
      end else begin
         b_done = (m_seq == 3) && (m_scnt == 0);
         b_tick = (m_phase == 2) && (m_tcnt == INTERVAL - 1);
         b_load = (m_phase == 0) && (m_pcnt == PAUSE - 1);
         n_pend = m_pend;
         if (b_load) n_pend = WARMUP;
         else begin
            if (b_done) n_pend = n_pend - 1;
            if (b_tick) begin
               if (n_pend == PMAX) m_ovf = 1'b1;
               else n_pend = n_pend + 1;
            end
         end
         n_seq = m_seq; n_scnt = m_scnt;
         case (m_seq)
            0: if (m_pend != 0 && ref_gnt) begin n_seq = 1; n_scnt = LEAD - 1; end
            1: if (m_scnt == 0) begin n_seq = 2; n_scnt = RASLO - 1; end else n_scnt = m_scnt - 1;
            2: if (m_scnt == 0) begin n_seq = 3; n_scnt = PRE - 1; end else n_scnt = m_scnt - 1;
            default: if (m_scnt == 0) n_seq = 0; else n_scnt = m_scnt - 1;
         endcase
         n_phase = m_phase; n_pcnt = m_pcnt;
         if (m_phase == 0) begin
            if (b_load) n_phase = 1; else n_pcnt = m_pcnt + 1;
         end else if (m_phase == 1 && m_pend == 0) n_phase = 2;
         if (m_phase != 2) n_tcnt = 0;
         else n_tcnt = (m_tcnt == INTERVAL - 1) ? 0 : m_tcnt + 1;
         m_phase = n_phase; m_pcnt = n_pcnt; m_pend = n_pend; m_tcnt = n_tcnt;
         m_seq = n_seq; m_scnt = n_scnt;
      end
   end

   // per-cycle comparison and strobe monitor
   bit prev_cas = 1'b1;
   int falls[$];
   int nfalls = 0;

   always @(negedge clk) begin
      if (cmp_en) begin
         chk(ras_n == (m_seq != 2), "R4", "ras_n vs model", ras_n, m_seq != 2);
         chk(cas_n == !(m_seq == 1 || m_seq == 2), "R4", "cas_n vs model",
             cas_n, !(m_seq == 1 || m_seq == 2));
         chk(we_n == 1'b1, "R6", "we_n", we_n, 1);
         chk(ref_req == (m_seq != 0 || m_pend != 0), "R5", "ref_req vs model",
             ref_req, m_seq != 0 || m_pend != 0);
         chk(ready == (m_phase == 2), "R2", "ready vs model", ready, m_phase == 2);
         chk(ovf_err == m_ovf, "R8", "ovf_err vs model", ovf_err, m_ovf);
         chk(host_gnt == (host_req && m_phase == 2), "R3", "host_gnt vs model",
             host_gnt, host_req && m_phase == 2);
         chk(!(!ras_n && cas_n), "R4", "ras low while cas high", ras_n, 1);
         if (prev_cas && !cas_n) begin
            falls.push_back(cyc);
            nfalls++;
         end
         prev_cas = cas_n;
      end
   end

   task automatic step(input int n);
      repeat (n) begin
         @(posedge clk);
         #1;
      end
   endtask

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      int rel_cyc, first_fall, f0, wait_n;
      host_req = 1'b1;
      step(1);
      cmp_en = 1'b1;
      step(3);
      // reset state
      chk(ready == 1'b0, "R2", "ready in reset", ready, 0);
      chk(ras_n && cas_n, "R4", "strobes idle in reset", {ras_n, cas_n}, 3);
      chk(ref_req == 1'b0, "R5", "ref_req in reset", ref_req, 0);
      chk(host_gnt == 1'b0, "R3", "host_gnt while not ready", host_gnt, 0);
      chk(ovf_err == 1'b0, "R8", "ovf_err in reset", ovf_err, 0);

      // start-up with grant always present
      rst_n = 1'b1;
      ref_gnt = 1'b1;
      rel_cyc = cyc;
      wait_n = 0;
      while (!ready && wait_n < 2000) begin step(1); wait_n++; end
      chk(ready == 1'b1, "R2", "ready reached", ready, 1);
      chk(nfalls == WARMUP, "R1", "warm-up cycles before ready", nfalls, WARMUP);
      first_fall = (falls.size() > 0) ? falls[0] : 0;
      chk(first_fall - rel_cyc >= PAUSE, "R1", "pause before first refresh",
          first_fall - rel_cyc, PAUSE);
      chk(host_gnt == 1'b1, "R3", "host_gnt once ready", host_gnt, 1);

      // steady running: window check
      falls.delete();
      step((ROWS + 3) * INTERVAL);
      chk(falls.size() >= ROWS + 1, "R9", "refreshes in steady run", falls.size(), ROWS + 1);
      for (int i = ROWS; i < falls.size(); i++)
         chk(falls[i] - falls[i - ROWS] <= ROWS * INTERVAL, "R9", "window of ROWS refreshes",
             falls[i] - falls[i - ROWS], ROWS * INTERVAL);
      host_req = 1'b0;
      step(2);
      chk(host_gnt == 1'b0, "R3", "host_gnt without request", host_gnt, 0);

      // withheld grant for a few intervals
      ref_gnt = 1'b0;
      f0 = nfalls;
      step(3 * INTERVAL);
      chk(nfalls == f0, "R5", "no refresh without grant", nfalls - f0, 0);
      chk(ref_req == 1'b1, "R7", "request raised while owed", ref_req, 1);
      ref_gnt = 1'b1;
      f0 = nfalls;
      step(2 * CYC_LEN + 2);
      chk(nfalls - f0 >= 2, "R7", "owed refreshes drain back to back", nfalls - f0, 2);
      step(2 * INTERVAL);

      // withheld grant past counter capacity
      ref_gnt = 1'b0;
      step((PMAX + 2) * INTERVAL);
      chk(ovf_err == 1'b1, "R8", "overflow flagged", ovf_err, 1);
      ref_gnt = 1'b1;
      f0 = nfalls;
      step(PMAX * CYC_LEN);
      chk(nfalls - f0 == PMAX, "R7", "saturated backlog drains back to back", nfalls - f0, PMAX);
      step(3 * INTERVAL);
      chk(ovf_err == 1'b1, "R8", "overflow sticky", ovf_err, 1);

      // reset in mid-run
      rst_n = 1'b0;
      step(2);
      chk(ovf_err == 1'b0, "R8", "overflow cleared by reset", ovf_err, 0);
      chk(ready == 1'b0, "R2", "ready cleared by reset", ready, 0);
      rst_n = 1'b1;
      step(PAUSE - 2);
      chk(ref_req == 1'b0, "R1", "no request during second pause", ref_req, 0);
      step(20);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule